// File: doc/BRIEF.md
# Rotate Execution Unit

This unit sits in the integer execute stage of a 64-bit core and handles the register-rotate instructions. Each cycle it receives the decoded instruction fields (the 5-bit source-register field, the 5-bit shift-amount field and the 6-bit function code) along with the two 64-bit source operand values. It works out whether the encoding names one of five rotate forms. If it does, it rotates the operand right by the selected amount and registers the result, a write enable and an is-rotate flag on the next rising clock edge.

Two of the forms work on the low 32-bit word and three work on the full 64-bit value. A rotate that takes an immediate amount is marked by `00001` in the source-register field. A rotate that takes a variable amount is marked by `00001` in the shift-amount field. That marker is what separates a rotate from the plain shifts that share its function codes. One 64-bit form adds 32 to its 5-bit immediate, so that the rotate amounts from 32 to 63 can be encoded. Any other encoding is reported as not-a-rotate.

Top module: `rot_unit`

## Requirements
- R1: Function `000010` with source field `00001` rotates bits 31:0 of the rt operand right by the 5-bit shift-amount field.
- R2: Function `000110` with shift-amount field `00001` rotates bits 31:0 of rt right by bits 4:0 of the rs operand. Bits 63:5 of rs have no effect.
- R3: Function `111010` with source field `00001` rotates all 64 bits of rt right by the shift-amount field, which covers amounts 0 to 31.
- R4: Function `111110` with source field `00001` rotates all 64 bits of rt right by the shift-amount field plus 32, which covers amounts 32 to 63.
- R5: Function `010110` with shift-amount field `00001` rotates all 64 bits of rt right by bits 5:0 of the rs operand. Bits 63:6 of rs have no effect.
- R6: A 32-bit rotate result is sign-extended from bit 31 into bits 63:32. Bits 63:32 of rt have no effect on it.
- R7: A rotate amount of zero returns the operand unchanged. For the 32-bit forms this is the sign-extended low word.
- R8: When valid is high and the encoding matches none of the five forms, wr_en_o and is_rot_o go low and result_o keeps its previous value. This covers the right function code with the marker field at `00000`.
- R9: Outputs are updated on the rising edge at which valid_i is high. When valid_i is low, both flags go low and result_o keeps its value.
- R10: The active-low asynchronous reset clears result_o, wr_en_o and is_rot_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction fields and operands are valid this cycle |
| rs_field_i | input | 5 | Source-register field of the instruction |
| sa_field_i | input | 5 | Shift-amount field of the instruction |
| funct_i | input | 6 | Function code of the instruction |
| rs_val_i | input | 64 | rs operand value (holds the variable amount) |
| rt_val_i | input | 64 | rt operand value (the data that is rotated) |
| result_o | output | 64 | Registered rotate result |
| wr_en_o | output | 1 | Registered write enable for the destination register |
| is_rot_o | output | 1 | Registered flag: the instruction was a rotate |

## Verification
The bench builds the unit with its default 64-bit data width. At that width the shift-amount register is six stages deep, so every stage of the barrel is exercised. The variable 64-bit form and the plus-32 form both reach the amounts 32 to 63, which the 32-bit word path cannot reach. Word-mode operands carry junk in their upper half, and rs values carry junk above the amount bits, so the tests show that those bits are masked. Amounts 0, 1, 31, 32 and 63 are each checked explicitly.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int FIELD_W = 5;
  localparam int FUNCT_W = 6;

  localparam logic [FIELD_W-1:0] ROT_MARK = 5'b00001;

  localparam logic [FUNCT_W-1:0] FN_W_IMM    = 6'b000010;
  localparam logic [FUNCT_W-1:0] FN_W_VAR    = 6'b000110;
  localparam logic [FUNCT_W-1:0] FN_D_IMM    = 6'b111010;
  localparam logic [FUNCT_W-1:0] FN_D_IMM_HI = 6'b111110;
  localparam logic [FUNCT_W-1:0] FN_D_VAR    = 6'b010110;

  typedef enum logic [2:0] {
    ROT_NONE,
    ROT_W_IMM,
    ROT_W_VAR,
    ROT_D_IMM,
    ROT_D_IMM_HI,
    ROT_D_VAR
  } rot_kind_e;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [FIELD_W-1:0] rs_field_i,
  input  logic [FIELD_W-1:0] sa_field_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [SHAMT_W-1:0] rs_amt_i,
  output logic               hit_o,
  output logic               word_o,
  output logic [SHAMT_W-1:0] amt_o
);
  localparam int HALF_W = DATA_W / 2;

  rot_kind_e kind;
  logic imm_mark, var_mark;

  assign imm_mark = (rs_field_i == ROT_MARK);
  assign var_mark = (sa_field_i == ROT_MARK);

  always_comb begin
    kind = ROT_NONE;
    unique case (funct_i)
      FN_W_IMM:    if (imm_mark) kind = ROT_W_IMM;
      FN_W_VAR:    if (var_mark) kind = ROT_W_VAR;
      FN_D_IMM:    if (imm_mark) kind = ROT_D_IMM;
      FN_D_IMM_HI: if (imm_mark) kind = ROT_D_IMM_HI;
      FN_D_VAR:    if (var_mark) kind = ROT_D_VAR;
      default:     kind = ROT_NONE;
    endcase
  end

  always_comb begin
    amt_o = '0;
    unique case (kind)
      ROT_W_IMM, ROT_D_IMM: amt_o = SHAMT_W'(sa_field_i);
      ROT_W_VAR:            amt_o = {1'b0, rs_amt_i[SHAMT_W-2:0]};
      ROT_D_IMM_HI:         amt_o = SHAMT_W'(HALF_W) + SHAMT_W'(sa_field_i);
      ROT_D_VAR:            amt_o = rs_amt_i;
      default:              amt_o = '0;
    endcase
  end

  assign hit_o  = (kind != ROT_NONE);
  assign word_o = (kind == ROT_W_IMM) || (kind == ROT_W_VAR);
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               word_i,
  output logic [DATA_W-1:0]  res_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0]  stg [SHAMT_W+1];
  logic [SHAMT_W-1:0] amt_eff;

  // word mode: duplicate low half so low half of the wide rotate is the narrow rotate
  assign stg[0]  = word_i ? {data_i[HALF_W-1:0], data_i[HALF_W-1:0]} : data_i;
  assign amt_eff = word_i ? {1'b0, amt_i[SHAMT_W-2:0]} : amt_i;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    localparam int S = 1 << i;
    assign stg[i+1] = amt_eff[i] ? {stg[i][S-1:0], stg[i][DATA_W-1:S]} : stg[i];
  end

  assign res_o = word_i ? {{HALF_W{stg[SHAMT_W][HALF_W-1]}}, stg[SHAMT_W][HALF_W-1:0]}
                        : stg[SHAMT_W];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FIELD_W-1:0] rs_field_i,
  input  logic [FIELD_W-1:0] sa_field_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_en_o,
  output logic               is_rot_o
);
  localparam int HALF_W = DATA_W / 2;

  logic               hit, word;
  logic [SHAMT_W-1:0] amt;
  logic [DATA_W-1:0]  rot_res;
  logic               unused_rs_hi;

  assign unused_rs_hi = ^rs_val_i[DATA_W-1:SHAMT_W];

  rot_decode #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dec (
    .rs_field_i (rs_field_i),
    .sa_field_i (sa_field_i),
    .funct_i    (funct_i),
    .rs_amt_i   (rs_val_i[SHAMT_W-1:0]),
    .hit_o      (hit),
    .word_o     (word),
    .amt_o      (amt)
  );

  rot_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_rot (
    .data_i (rt_val_i),
    .amt_i  (amt),
    .word_i (word),
    .res_o  (rot_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      is_rot_o <= 1'b0;
    end else begin
      wr_en_o  <= valid_i && hit;
      is_rot_o <= valid_i && hit;
      if (valid_i && hit) result_o <= rot_res;
    end
  end

  // R8
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !hit |=> !wr_en_o && !is_rot_o && $stable(result_o));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o && !is_rot_o && $stable(result_o));

  // R6
  sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && hit && word |=> result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}});

  // R7
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && hit && !word && amt == '0 |=> result_o == $past(rt_val_i));

  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && hit |=> wr_en_o && is_rot_o);
endmodule

// File: tb/rot_unit_tb_top.sv
module rot_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  rs_field_i = '0;
  logic [4:0]  sa_field_i = '0;
  logic [5:0]  funct_i = '0;
  logic [63:0] rs_val_i = '0;
  logic [63:0] rt_val_i = '0;
  logic [63:0] result_o;
  logic        wr_en_o, is_rot_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] last_res = '0;

  always #5 clk_i = ~clk_i;

  rot_unit dut_i (.*);

  function automatic logic [63:0] ror64(logic [63:0] v, int k);
    for (int i = 0; i < k; i++) v = {v[0], v[63:1]};
    return v;
  endfunction

  function automatic logic [63:0] ror32s(logic [63:0] v, int k);
    logic [31:0] w = v[31:0];
    for (int i = 0; i < k; i++) w = {w[0], w[31:1]};
    return {{32{w[31]}}, w};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one instruction, check after the capturing edge
  task automatic issue(string req, logic [4:0] rsf, logic [4:0] saf, logic [5:0] fn,
                       logic [63:0] rsv, logic [63:0] rtv, bit exp_hit, logic [63:0] exp_res);
    @(negedge clk_i);
    valid_i = 1'b1; rs_field_i = rsf; sa_field_i = saf; funct_i = fn;
    rs_val_i = rsv; rt_val_i = rtv;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (exp_hit) last_res = exp_res;
    chk(req, result_o, last_res);
    chk(req, {63'd0, wr_en_o}, {63'd0, exp_hit});
    chk(req, {63'd0, is_rot_o}, {63'd0, exp_hit});
  endtask

  localparam logic [63:0] PAT = 64'hA5C3_0F96_8001_7E24;

  task automatic t_reset();
    chk("R10", result_o, 64'd0);
    chk("R10", {62'd0, wr_en_o, is_rot_o}, 64'd0);
  endtask

  task automatic t_word_imm();
    issue("R1", 5'd1, 5'd4, 6'b000010, '0, 64'hFFFF_0000_1234_5678, 1, ror32s(64'h1234_5678, 4));
    issue("R1", 5'd1, 5'd31, 6'b000010, '0, PAT, 1, ror32s(PAT, 31));
    issue("R6", 5'd1, 5'd1, 6'b000010, '0, 64'h0000_0000_0000_0001, 1, 64'hFFFF_FFFF_8000_0000);
  endtask

  task automatic t_word_var();
    issue("R2", 5'd0, 5'd1, 6'b000110, 64'hFFFF_FFFF_FFFF_FFE8, PAT, 1, ror32s(PAT, 8));
    issue("R2", 5'd7, 5'd1, 6'b000110, 64'h0000_0000_0000_0033, PAT, 1, ror32s(PAT, 19));
  endtask

  task automatic t_dbl_imm();
    issue("R3", 5'd1, 5'd1, 6'b111010, '0, PAT, 1, ror64(PAT, 1));
    issue("R3", 5'd1, 5'd31, 6'b111010, '0, PAT, 1, ror64(PAT, 31));
  endtask

  task automatic t_dbl_hi();
    issue("R4", 5'd1, 5'd0, 6'b111110, '0, PAT, 1, ror64(PAT, 32));
    issue("R4", 5'd1, 5'd31, 6'b111110, '0, PAT, 1, ror64(PAT, 63));
    issue("R4", 5'd1, 5'd5, 6'b111110, '0, 64'h1, 1, ror64(64'h1, 37));
  endtask

  task automatic t_dbl_var();
    issue("R5", 5'd3, 5'd1, 6'b010110, 64'hFFFF_FFFF_FFFF_FFFF, PAT, 1, ror64(PAT, 63));
    issue("R5", 5'd0, 5'd1, 6'b010110, 64'h8000_0000_0000_0028, PAT, 1, ror64(PAT, 40));
  endtask

  task automatic t_zero();
    issue("R7", 5'd1, 5'd0, 6'b111010, '0, PAT, 1, PAT);
    issue("R7", 5'd0, 5'd1, 6'b010110, 64'h40, PAT, 1, PAT);
    issue("R7", 5'd1, 5'd0, 6'b000010, '0, PAT, 1, {{32{PAT[31]}}, PAT[31:0]});
  endtask

  task automatic t_reject();
    issue("R8", 5'd0, 5'd4, 6'b000010, '0, PAT, 0, '0);
    issue("R8", 5'd1, 5'd0, 6'b000110, 64'h3, PAT, 0, '0);
    issue("R8", 5'd2, 5'd3, 6'b111010, '0, PAT, 0, '0);
    issue("R8", 5'd1, 5'd1, 6'b000000, '0, PAT, 0, '0);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    rs_field_i = 5'd1; sa_field_i = 5'd9; funct_i = 6'b111010; rt_val_i = 64'h1;
    @(negedge clk_i);
    chk("R9", result_o, last_res);
    chk("R9", {62'd0, wr_en_o, is_rot_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_word_imm();
    t_word_var();
    t_dbl_imm();
    t_dbl_hi();
    t_dbl_var();
    t_zero();
    t_reject();
    t_idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule